// File: doc/BRIEF.md
# Per-Stream Input Frame Offset and Skew Evaluator

This block lines up serial input streams that arrive late against the frame pulse. Each stream has its own offset register. The offset sets how many half master-clock steps that stream's channel alignment pulse trails the frame reference. The block runs on a sampling clock at twice the master clock, so one offset unit equals one sampling cycle. A write is checked against the limit for the selected line rate. A write above the limit is refused, and a status bit records the refusal.

A measurement mode finds the offset to use. Software holds the start bit low for at least one full frame, then raises it. At the next frame pulse the block begins counting sampling cycles. It stops at the first rising edge of the evaluation input. The count is latched into a readable result and a done flag is set. The done flag stays set until the start bit is lowered.

Top module: `frame_skew_ctrl`

## Requirements
- R1: After reset, every offset register reads 0, the reject flag is 0, the done flag is 0 and the measurement result is 0.
- R2: An offset write whose value is within the limit for the selected rate is stored in the selected stream's register. It is visible on `ofs_o` (stream s at bits s*OFS_W upward) on the next cycle, and the write clears the reject flag.
- R3: The limit is 5 half-steps when `rate_hi_i`=1 and 9 half-steps when `rate_hi_i`=0. A write above the limit leaves every offset register unchanged and sets the reject flag, which holds until the next accepted write.
- R4: `align_o[s]` is high exactly in the cycle that comes `ofs[s]` cycles after a cycle in which `frame_i` was high. An offset of 0 passes the frame pulse through in the same cycle. Each stream follows only its own offset.
- R5: A rising edge of `start_i` starts a measurement only after `start_i` has been low for at least FRAME_LEN consecutive cycles. Otherwise the edge is ignored: no done flag follows, and the result is unchanged.
- R6: Once started, the result is the number of cycles from the next frame pulse to the first rising edge of `eval_i`. An edge in the same cycle as the pulse gives 0. An input that is already high at the pulse is not an edge.
- R7: If a further frame pulse arrives before any rising edge of `eval_i`, the measurement ends with a result of all ones (127 by default).
- R8: The done flag rises in the same cycle the result is stored. The flag and the result hold while `start_i` stays high. The flag clears one cycle after `start_i` goes low, and the result is kept.
- R9: Lowering `start_i` before a measurement completes aborts it. No done flag follows, and the result is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock, twice the master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Frame pulse, one cycle high |
| eval_i | input | 1 | Frame-evaluation input |
| rate_hi_i | input | 1 | 1 selects the high-rate offset limit |
| ofs_wr_i | input | 1 | Offset write strobe |
| ofs_sel_i | input | SEL_W | Stream index for the write |
| ofs_val_i | input | OFS_W | Offset value in half-clock steps |
| start_i | input | 1 | Measurement start bit |
| ofs_o | output | N_STREAMS*OFS_W | All offset registers, packed |
| ofs_err_o | output | 1 | Last offset write was refused |
| align_o | output | N_STREAMS | Delayed per-stream alignment pulse |
| meas_o | output | CNT_W | Measured skew in half-clock steps |
| done_o | output | 1 | Measurement result valid |

## Verification
The assertions check on every cycle that an offset write is either refused with the registers unchanged or stored with the flag cleared. They also check that the result moves only when the done flag rises, that the flag drops after the start bit falls, and that a unit or zero offset gives the right alignment tap. The bench scenarios cover the rest. These are the full range of alignment delays, the one-frame arming window, the skew counts for edges at several distances, an input that is already high at the pulse, the timeout value, and an aborted measurement.

// File: rtl/frame_skew_pkg.sv
package frame_skew_pkg;
  typedef enum logic [1:0] {
    MS_IDLE    = 2'd0,
    MS_WAIT_FP = 2'd1,
    MS_COUNT   = 2'd2,
    MS_DONE    = 2'd3
  } meas_state_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ofs_regs.sv
module ofs_regs #(
  parameter int N_STREAMS = 4,
  parameter int OFS_W     = 4,
  parameter int MAX_LO    = 9,
  parameter int MAX_HI    = 5,
  parameter int SEL_W     = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  logic [SEL_W-1:0]           sel_i,
  input  logic [OFS_W-1:0]           val_i,
  input  logic                       rate_hi_i,
  output logic [N_STREAMS*OFS_W-1:0] ofs_o,
  output logic                       err_o
);
  logic [OFS_W-1:0] limit;
  logic             ok;

  assign limit = rate_hi_i ? OFS_W'(MAX_HI) : OFS_W'(MAX_LO);
  assign ok    = (val_i <= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   err_o <= 1'b0;
    else if (wr_i) err_o <= !ok;
  end

  for (genvar s = 0; s < N_STREAMS; s++) begin : g_reg
    logic [OFS_W-1:0] r;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 r <= '0;
      else if (wr_i && ok && sel_i == SEL_W'(s))   r <= val_i;
    end
    assign ofs_o[s*OFS_W +: OFS_W] = r;
  end
endmodule

// File: rtl/frame_align.sv
module frame_align #(
  parameter int N_STREAMS = 4,
  parameter int OFS_W     = 4,
  parameter int DEPTH     = 9
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       frame_i,
  input  logic [N_STREAMS*OFS_W-1:0] ofs_i,
  output logic [N_STREAMS-1:0]       align_o
);
  logic [DEPTH-1:0] dly;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dly <= '0;
    else begin
      dly[0] <= frame_i;
      for (int j = 1; j < DEPTH; j++) dly[j] <= dly[j-1];
    end
  end

  for (genvar s = 0; s < N_STREAMS; s++) begin : g_tap
    logic [OFS_W-1:0] tap;
    assign tap = ofs_i[s*OFS_W +: OFS_W];
    always_comb begin
      align_o[s] = 1'b0;
      if (tap == '0) align_o[s] = frame_i;
      else begin
        for (int j = 1; j <= DEPTH; j++)
          if (int'(tap) == j) align_o[s] = dly[j-1];
      end
    end
  end
endmodule

// File: rtl/skew_meas.sv
module skew_meas
  import frame_skew_pkg::*;
#(
  parameter int FRAME_LEN = 64,
  parameter int CNT_W     = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_i,
  input  logic             eval_i,
  input  logic             start_i,
  output logic [CNT_W-1:0] meas_o,
  output logic             done_o
);
  localparam int LOW_W = $clog2(FRAME_LEN + 1);

  meas_state_e      state_q;
  logic [LOW_W-1:0] low_cnt;
  logic [CNT_W-1:0] cnt;
  logic             start_q, eval_q;
  logic             armed, go, edge_seen;

  assign armed     = (low_cnt == LOW_W'(FRAME_LEN));
  assign go        = start_i && !start_q && armed;
  assign edge_seen = eval_i && !eval_q;
  assign done_o    = (state_q == MS_DONE);

  // consecutive low cycles of the start bit, saturating at one frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       low_cnt <= '0;
    else if (start_i)  low_cnt <= '0;
    else if (!armed)   low_cnt <= low_cnt + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      eval_q  <= 1'b0;
    end else begin
      start_q <= start_i;
      eval_q  <= eval_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MS_IDLE;
      cnt     <= '0;
      meas_o  <= '0;
    end else if (!start_i) begin
      state_q <= MS_IDLE;
    end else begin
      unique case (state_q)
        MS_IDLE: if (go) state_q <= MS_WAIT_FP;
        MS_WAIT_FP: begin
          if (frame_i) begin
            if (edge_seen) begin
              meas_o  <= '0;
              state_q <= MS_DONE;
            end else begin
              cnt     <= CNT_W'(1);
              state_q <= MS_COUNT;
            end
          end
        end
        MS_COUNT: begin
          if (frame_i) begin
            meas_o  <= '1;
            state_q <= MS_DONE;
          end else if (edge_seen) begin
            meas_o  <= cnt;
            state_q <= MS_DONE;
          end else if (cnt != '1) begin
            cnt <= cnt + 1'b1;
          end
        end
        MS_DONE: state_q <= MS_DONE;
        default: state_q <= MS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/frame_skew_ctrl.sv
module frame_skew_ctrl
  import frame_skew_pkg::*;
#(
  parameter int N_STREAMS = 4,
  parameter int OFS_W     = 4,
  parameter int MAX_LO    = 9,
  parameter int MAX_HI    = 5,
  parameter int FRAME_LEN = 64,
  localparam int SEL_W    = (N_STREAMS > 1) ? $clog2(N_STREAMS) : 1,
  localparam int CNT_W    = $clog2(FRAME_LEN) + 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       frame_i,
  input  logic                       eval_i,
  input  logic                       rate_hi_i,
  input  logic                       ofs_wr_i,
  input  logic [SEL_W-1:0]           ofs_sel_i,
  input  logic [OFS_W-1:0]           ofs_val_i,
  input  logic                       start_i,
  output logic [N_STREAMS*OFS_W-1:0] ofs_o,
  output logic                       ofs_err_o,
  output logic [N_STREAMS-1:0]       align_o,
  output logic [CNT_W-1:0]           meas_o,
  output logic                       done_o
);
  localparam int DEPTH = max_int(MAX_LO, MAX_HI);

  ofs_regs #(
    .N_STREAMS(N_STREAMS), .OFS_W(OFS_W), .MAX_LO(MAX_LO),
    .MAX_HI(MAX_HI), .SEL_W(SEL_W)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(ofs_wr_i), .sel_i(ofs_sel_i),
    .val_i(ofs_val_i), .rate_hi_i(rate_hi_i), .ofs_o(ofs_o), .err_o(ofs_err_o)
  );

  frame_align #(
    .N_STREAMS(N_STREAMS), .OFS_W(OFS_W), .DEPTH(DEPTH)
  ) u_align (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_i(frame_i),
    .ofs_i(ofs_o), .align_o(align_o)
  );

  skew_meas #(
    .FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)
  ) u_meas (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_i(frame_i), .eval_i(eval_i),
    .start_i(start_i), .meas_o(meas_o), .done_o(done_o)
  );
endmodule

// File: rtl/frame_skew_ctrl_chk.sv
module frame_skew_ctrl_chk #(
  parameter int N_STREAMS = 4,
  parameter int OFS_W     = 4,
  parameter int MAX_LO    = 9,
  parameter int MAX_HI    = 5,
  parameter int SEL_W     = 2,
  parameter int CNT_W     = 7
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       frame_i,
  input logic                       rate_hi_i,
  input logic                       ofs_wr_i,
  input logic [SEL_W-1:0]           ofs_sel_i,
  input logic [OFS_W-1:0]           ofs_val_i,
  input logic                       start_i,
  input logic [N_STREAMS*OFS_W-1:0] ofs_o,
  input logic                       ofs_err_o,
  input logic [N_STREAMS-1:0]       align_o,
  input logic [CNT_W-1:0]           meas_o,
  input logic                       done_o
);
  logic [OFS_W-1:0] lim;
  assign lim = rate_hi_i ? OFS_W'(MAX_HI) : OFS_W'(MAX_LO);

  a_r3_reject_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ofs_wr_i && ofs_val_i > lim) |=> (ofs_err_o && ofs_o == $past(ofs_o)));

  a_r2_accept_stores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ofs_wr_i && ofs_val_i <= lim && int'(ofs_sel_i) < N_STREAMS) |=>
      (!ofs_err_o && ofs_o[int'($past(ofs_sel_i))*OFS_W +: OFS_W] == $past(ofs_val_i)));

  a_r8_done_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o);

  a_r8_meas_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(done_o) |-> $stable(meas_o));

  a_r9_done_needs_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(start_i));

  for (genvar s = 0; s < N_STREAMS; s++) begin : g_chk
    a_r4_unit_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frame_i && !ofs_wr_i && ofs_o[s*OFS_W +: OFS_W] == OFS_W'(1)) |=> align_o[s]);
    a_r4_zero_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ofs_o[s*OFS_W +: OFS_W] == '0) |-> (align_o[s] == frame_i));
  end
endmodule

bind frame_skew_ctrl frame_skew_ctrl_chk #(
  .N_STREAMS(N_STREAMS), .OFS_W(OFS_W), .MAX_LO(MAX_LO), .MAX_HI(MAX_HI),
  .SEL_W(SEL_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .frame_i(frame_i), .rate_hi_i(rate_hi_i),
  .ofs_wr_i(ofs_wr_i), .ofs_sel_i(ofs_sel_i), .ofs_val_i(ofs_val_i),
  .start_i(start_i), .ofs_o(ofs_o), .ofs_err_o(ofs_err_o), .align_o(align_o),
  .meas_o(meas_o), .done_o(done_o)
);

// File: tb/sim_frame_skew_ctrl.sv
module sim_frame_skew_ctrl;
  localparam int N = 4;
  localparam int OFS_W = 4;
  localparam int FRAME_LEN = 64;
  localparam int CNT_W = 7;
  localparam int ALL1 = 127;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic frame = 1'b0, eval_in = 1'b0, rate_hi = 1'b0, wr = 1'b0, start = 1'b0;
  logic [1:0] sel = '0;
  logic [OFS_W-1:0] val = '0;
  logic [N*OFS_W-1:0] ofs;
  logic ofs_err, done;
  logic [N-1:0] align;
  logic [CNT_W-1:0] meas;
  int checks = 0;
  int errors = 0;
  int exp_ofs [N];

  always #5 clk = ~clk;

  frame_skew_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .frame_i(frame), .eval_i(eval_in),
    .rate_hi_i(rate_hi), .ofs_wr_i(wr), .ofs_sel_i(sel), .ofs_val_i(val),
    .start_i(start), .ofs_o(ofs), .ofs_err_o(ofs_err), .align_o(align),
    .meas_o(meas), .done_o(done)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  function automatic int ofs_of(int s);
    return int'(ofs[s*OFS_W +: OFS_W]);
  endfunction

  task automatic wr_ofs(int s, int v, bit hi);
    rate_hi = hi; wr = 1'b1; sel = 2'(s); val = OFS_W'(v);
    tick();
    wr = 1'b0;
  endtask

  task automatic t_reset();
    for (int s = 0; s < N; s++) check("R1 offset", ofs_of(s), 0);
    check("R1 err", int'(ofs_err), 0);
    check("R1 done", int'(done), 0);
    check("R1 meas", int'(meas), 0);
  endtask

  task automatic t_write();
    wr_ofs(1, 9, 0);
    check("R2 s1", ofs_of(1), 9); check("R2 err", int'(ofs_err), 0);
    wr_ofs(3, 3, 0);
    check("R2 s3", ofs_of(3), 3);
    check("R2 s1 kept", ofs_of(1), 9);
  endtask

  task automatic t_reject();
    wr_ofs(1, 6, 1);
    check("R3 hi reject keep", ofs_of(1), 9); check("R3 err set", int'(ofs_err), 1);
    tick(2);
    check("R3 err holds", int'(ofs_err), 1);
    wr_ofs(2, 5, 1);
    check("R3 hi limit ok", ofs_of(2), 5); check("R2 err clear", int'(ofs_err), 0);
    wr_ofs(2, 10, 0);
    check("R3 lo reject keep", ofs_of(2), 5); check("R3 err set lo", int'(ofs_err), 1);
    wr_ofs(0, 0, 0);
    check("R2 s0 zero", ofs_of(0), 0); check("R2 err clear2", int'(ofs_err), 0);
    exp_ofs[0] = 0; exp_ofs[1] = 9; exp_ofs[2] = 5; exp_ofs[3] = 3;
  endtask

  task automatic t_align();
    frame = 1'b1;
    for (int j = 0; j < 12; j++) begin
      #1;
      for (int s = 0; s < N; s++)
        check($sformatf("R4 s%0d t%0d", s, j), int'(align[s]), (j == exp_ofs[s]) ? 1 : 0);
      @(negedge clk);
      if (j == 0) frame = 1'b0;
    end
  endtask

  task automatic start_meas();
    start = 1'b0;
    tick(FRAME_LEN + 2);
    start = 1'b1;
    tick(2);
  endtask

  task automatic t_meas_edge(int k);
    start_meas();
    frame = 1'b1;
    if (k == 0) eval_in = 1'b1;
    tick();
    frame = 1'b0;
    if (k > 0) begin
      tick(k - 1);
      eval_in = 1'b1;
      tick();
    end
    check($sformatf("R6 skew %0d", k), int'(meas), k);
    check("R8 done set", int'(done), 1);
    tick(3);
    check("R8 done held", int'(done), 1);
    check("R8 meas held", int'(meas), k);
    start = 1'b0;
    tick();
    check("R8 done cleared", int'(done), 0);
    check("R8 meas kept", int'(meas), k);
    eval_in = 1'b0;
  endtask

  task automatic t_meas_high_at_pulse();
    eval_in = 1'b1;
    start_meas();
    frame = 1'b1;
    tick();
    frame = 1'b0;
    tick();
    eval_in = 1'b0;
    tick(3);
    eval_in = 1'b1;
    tick();
    check("R6 level not edge", int'(meas), 5);
    check("R6 done", int'(done), 1);
    start = 1'b0; eval_in = 1'b0;
    tick();
  endtask

  task automatic t_timeout();
    start_meas();
    frame = 1'b1; tick(); frame = 1'b0;
    tick(9);
    check("R7 not yet done", int'(done), 0);
    frame = 1'b1; tick(); frame = 1'b0;
    check("R7 all ones", int'(meas), ALL1);
    check("R7 done", int'(done), 1);
    start = 1'b0;
    tick();
  endtask

  task automatic t_not_armed();
    start = 1'b0;
    tick(10);
    start = 1'b1;
    tick(2);
    frame = 1'b1; tick(); frame = 1'b0;
    tick(2);
    eval_in = 1'b1;
    tick(3);
    check("R5 no done", int'(done), 0);
    check("R5 meas unchanged", int'(meas), ALL1);
    eval_in = 1'b0; start = 1'b0;
    tick();
  endtask

  task automatic t_abort();
    start_meas();
    frame = 1'b1; tick(); frame = 1'b0;
    tick();
    start = 1'b0;
    tick(2);
    eval_in = 1'b1;
    tick(2);
    check("R9 no done", int'(done), 0);
    check("R9 meas unchanged", int'(meas), ALL1);
    eval_in = 1'b0;
    tick();
  endtask

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_write();
    t_reject();
    t_align();
    t_meas_edge(0);
    t_meas_edge(7);
    t_meas_edge(20);
    t_meas_high_at_pulse();
    t_timeout();
    t_not_armed();
    t_abort();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule